// File: doc/BRIEF.md
# Edge-Qualified Status Interrupt Register Bank

This block keeps five asynchronous line-status inputs (ID grounded, session ended, session valid, bus voltage valid, host disconnected) together with a small control register and two per-bit interrupt enable masks. One mask qualifies low-to-high changes and the other qualifies high-to-low changes. The status inputs are brought into the clock domain by a two-stage synchronizer. An enabled change then raises a sticky interrupt level and a single-cycle event strobe, and the strobe carries a snapshot of the five status bits.

Software reaches the three registers through a byte-wide register port. Each register answers at three consecutive addresses. The lowest address replaces the register, the next one ORs the written byte into it, and the highest one clears the bits that are 1 in the written byte. Reads are combinational from the address and return the register at any of its three addresses. The control register drives two pull-down enables and an ID sampling enable. While ID sampling is off, the ID status bit is forced to 0.

Top module: `edgeIrqRegBank`

## Requirements
- R1: Each register has three addresses at base, base+1 and base+2: a plain write, a set (register OR data) and a clear (register AND NOT data). The bases are 0Ah for control, 0Dh for the rising-edge enables and 10h for the falling-edge enables. A write takes effect at the clock edge where `regWrEn` is 1.
- R2: `regRdData` returns the current register at any of its three addresses, and returns 0 for every other address.
- R3: A write to any address outside 0Ah..12h changes no register.
- R4: Enable bits: bit 4 ID ground, bit 3 session end, bit 2 session valid, bit 1 bus voltage valid, bit 0 host disconnect. `statusIn` uses the same bit order. Control bits: bit 2 drives `dmPullDown`, bit 1 drives `dpPullDown`, bit 0 drives `idSampleEn`. Unused upper bits read as 0.
- R5: After reset, both enable registers read 1Fh and control reads 06h. `irqOut` and `evtValid` are 0.
- R6: A 0-to-1 change on a status bit whose rising enable is 1 gives `evtValid` = 1 for one cycle. The strobe follows the third rising clock edge after the input changes.
- R7: A 1-to-0 change on a status bit whose falling enable is 1 produces the same event, with the same latency.
- R8: A change whose direction is not enabled for that bit produces no event and does not set `irqOut`.
- R9: While control bit 0 is 0, status bit 4 is treated as 0 for edge detection and in `evtStatus`. Setting control bit 0 while the ID input is high is seen as a rising change on bit 4.
- R10: `irqOut` is set on the same edge as `evtValid`. It stays set until an edge where `irqAck` is 1 and no new event fires. A new event wins over an acknowledge in the same cycle.
- R11: `evtStatus` shows the five synchronized status bits captured with the latest event, and holds them until the next event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register address |
| regWrEn | input | 1 | Write strobe for the address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| statusIn | input | 5 | Asynchronous status lines |
| irqAck | input | 1 | Interrupt acknowledge |
| irqOut | output | 1 | Sticky interrupt |
| evtValid | output | 1 | One-cycle event strobe |
| evtStatus | output | 5 | Status snapshot of the latest event |
| dmPullDown | output | 1 | DM pull-down enable (control bit 2) |
| dpPullDown | output | 1 | DP pull-down enable (control bit 1) |
| idSampleEn | output | 1 | ID pull-up and sampling enable (control bit 0) |

## Verification
The assertions check on every cycle that an event always sets the interrupt, that the interrupt holds until acknowledged, that an acknowledge without a new event clears it, that every event reflects a real change of the synchronized status, and that a snapshot taken with ID sampling off shows bit 4 low. The bench scenarios are the only way to show the alias arithmetic and the unmapped-address behaviour. They also cover the three-edge latency, the per-direction masking of each bit and the reset values.

// File: rtl/edgeIrqPkg.sv
package edgeIrqPkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_RISE = 2'd2,
    REG_FALL = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } wrOp_e;

  // strobes from address decode to the register datapath
  typedef struct packed {
    logic    wrStb;
    regSel_e sel;
    wrOp_e   op;
  } regStb_t;

  localparam int NUM_REGS = 3;
  localparam int ALIAS_SPAN = 3;

endpackage

// File: rtl/edgeIrqCtrl.sv
module edgeIrqCtrl
  import edgeIrqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 6'h0A,
  parameter logic [ADDR_W-1:0] RISE_BASE = 6'h0D,
  parameter logic [ADDR_W-1:0] FALL_BASE = 6'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStb_t           stb
);

  localparam logic [ADDR_W-1:0] BASES [NUM_REGS] = '{CTRL_BASE, RISE_BASE, FALL_BASE};

  logic [NUM_REGS-1:0] hitVec;
  logic [1:0]          offVec [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_win
    logic [ADDR_W-1:0] diff;
    assign diff      = regAddr - BASES[r];
    assign hitVec[r] = (diff < ADDR_W'(ALIAS_SPAN));
    assign offVec[r] = diff[1:0];
  end

  always_comb begin
    stb.sel = REG_NONE;
    stb.op  = OP_WRITE;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (hitVec[r]) begin
        stb.sel = regSel_e'(2'(r + 1));
        stb.op  = wrOp_e'(offVec[r]);
      end
    end
    stb.wrStb = regWrEn && (stb.sel != REG_NONE);
  end

  // R1: a decoded alias never yields the unused operation code
  p_op_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sel != REG_NONE) |-> (stb.op != 2'd3));

endmodule

// File: rtl/edgeIrqData.sv
module edgeIrqData
  import edgeIrqPkg::*;
#(
  parameter int STAT_W      = 5,
  parameter int DATA_W      = 8,
  parameter int CTRL_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ID_BIT      = 4,
  parameter int ID_CTRL_BIT = 0,
  parameter logic [STAT_W-1:0] EN_RESET   = '1,
  parameter logic [CTRL_W-1:0] CTRL_RESET = 3'b110
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              irqAck,
  output logic              irqOut,
  output logic              evtValid,
  output logic [STAT_W-1:0] evtStatus,
  output logic [CTRL_W-1:0] ctrlOut
);

  function automatic logic [STAT_W-1:0] applyOp(input logic [STAT_W-1:0] cur,
                                                input logic [STAT_W-1:0] d,
                                                input wrOp_e op);
    case (op)
      OP_SET:   return cur | d;
      OP_CLEAR: return cur & ~d;
      default:  return d;
    endcase
  endfunction

  logic [CTRL_W-1:0] ctrlReg;
  logic [STAT_W-1:0] riseEn, fallEn;
  logic [STAT_W-1:0] wrLow, ctrlExt, ctrlNext;
  logic [STAT_W-1:0] syncQ [SYNC_STAGES];
  logic [STAT_W-1:0] effStat, prevStat, riseHit, fallHit;
  logic              anyHit;
  logic              unusedBits;

  assign wrLow      = wrData[STAT_W-1:0];
  assign ctrlExt    = STAT_W'(ctrlReg);
  assign ctrlNext   = applyOp(ctrlExt, wrLow, stb.op);
  assign unusedBits = ^{wrData[DATA_W-1:STAT_W], ctrlNext[STAT_W-1:CTRL_W]};

  // register writes through write/set/clear aliases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      riseEn  <= EN_RESET;
      fallEn  <= EN_RESET;
    end else if (stb.wrStb) begin
      case (stb.sel)
        REG_CTRL: ctrlReg <= ctrlNext[CTRL_W-1:0];
        REG_RISE: riseEn  <= applyOp(riseEn, wrLow, stb.op);
        REG_FALL: fallEn  <= applyOp(fallEn, wrLow, stb.op);
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (stb.sel)
      REG_CTRL: rdData = DATA_W'(ctrlReg);
      REG_RISE: rdData = DATA_W'(riseEn);
      REG_FALL: rdData = DATA_W'(fallEn);
      default:  rdData = '0;
    endcase
  end

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= statusIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_comb begin
    effStat         = syncQ[SYNC_STAGES-1];
    effStat[ID_BIT] = effStat[ID_BIT] & ctrlReg[ID_CTRL_BIT];
  end

  assign riseHit = effStat & ~prevStat & riseEn;
  assign fallHit = ~effStat & prevStat & fallEn;
  assign anyHit  = |(riseHit | fallHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStat  <= '0;
      evtValid  <= 1'b0;
      evtStatus <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevStat <= effStat;
      evtValid <= anyHit;
      if (anyHit) evtStatus <= effStat;
      irqOut   <= anyHit | (irqOut & ~irqAck);
    end
  end

  assign ctrlOut = ctrlReg;

  // R10: an event strobe always comes with the interrupt raised
  p_evt_sets_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> irqOut);

  // R10: the interrupt holds while not acknowledged
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqAck) |=> irqOut);

  // R10: acknowledge without a new event drops the interrupt
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqAck) && !evtValid) |-> !irqOut);

  // R6: an event reflects a real change of the synchronized status
  p_evt_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtStatus != $past(prevStat)));

  // R9: a snapshot taken with ID sampling off shows ID low
  p_id_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !$past(ctrlReg[ID_CTRL_BIT])) |-> !evtStatus[ID_BIT]);

endmodule

// File: rtl/edgeIrqRegBank.sv
module edgeIrqRegBank
  import edgeIrqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              irqAck,
  output logic              irqOut,
  output logic              evtValid,
  output logic [STAT_W-1:0] evtStatus,
  output logic              dmPullDown,
  output logic              dpPullDown,
  output logic              idSampleEn
);

  localparam int CTRL_W = 3;

  regStb_t           stb;
  logic [CTRL_W-1:0] ctrlBits;

  edgeIrqCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  edgeIrqData #(.STAT_W(STAT_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .statusIn  (statusIn),
    .irqAck    (irqAck),
    .irqOut    (irqOut),
    .evtValid  (evtValid),
    .evtStatus (evtStatus),
    .ctrlOut   (ctrlBits)
  );

  assign dmPullDown = ctrlBits[2];
  assign dpPullDown = ctrlBits[1];
  assign idSampleEn = ctrlBits[0];

endmodule

// File: tb/test_edgeIrqRegBank.sv
module test_edgeIrqRegBank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [4:0] statusIn = '0;
  logic       irqAck = 1'b0;
  logic       irqOut, evtValid;
  logic [4:0] evtStatus;
  logic       dmPullDown, dpPullDown, idSampleEn;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  edgeIrqRegBank i_edgeIrqRegBank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .statusIn(statusIn),
    .irqAck(irqAck), .irqOut(irqOut), .evtValid(evtValid),
    .evtStatus(evtStatus), .dmPullDown(dmPullDown), .dpPullDown(dpPullDown),
    .idSampleEn(idSampleEn)
  );

  // reference state, built from the requirements
  logic [2:0] mCtrl;
  logic [4:0] mRise, mFall;
  logic [4:0] mS1, mS2, mPrev, mEvtS;
  logic       mIrq, mEvt;

  function automatic logic [7:0] rdModel(input logic [5:0] a);
    if (a >= 6'h0A && a <= 6'h0C) return {5'b0, mCtrl};
    if (a >= 6'h0D && a <= 6'h0F) return {3'b0, mRise};
    if (a >= 6'h10 && a <= 6'h12) return {3'b0, mFall};
    return 8'h00;
  endfunction

  function automatic logic [4:0] opModel(input logic [4:0] cur, input logic [4:0] d,
                                         input int off);
    if (off == 0) return d;
    if (off == 1) return cur | d;
    return cur & ~d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2 read", regRdData, rdModel(regAddr));
    chk("R6 evtValid", evtValid, mEvt);
    chk("R11 evtStatus", evtStatus, mEvtS);
    chk("R10 irqOut", irqOut, mIrq);
    chk("R4 control pins", {dmPullDown, dpPullDown, idSampleEn}, mCtrl);
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input logic [5:0] a, input logic we, input logic [7:0] d,
                      input logic [4:0] st, input logic ack);
    logic [4:0] eff, rise, fall;
    logic       hit;
    regAddr = a; regWrEn = we; regWrData = d; statusIn = st; irqAck = ack;
    eff    = mS2;
    eff[4] = eff[4] & mCtrl[0];
    rise   = eff & ~mPrev & mRise;
    fall   = ~eff & mPrev & mFall;
    hit    = |(rise | fall);
    @(posedge clk);
    mS2 = mS1; mS1 = st; mPrev = eff; mEvt = hit;
    if (hit) mEvtS = eff;
    mIrq = hit | (mIrq & ~ack);
    if (we) begin
      if (a >= 6'h0A && a <= 6'h0C) mCtrl = opModel({2'b0, mCtrl}, d[4:0], int'(a - 6'h0A))[2:0];
      else if (a >= 6'h0D && a <= 6'h0F) mRise = opModel(mRise, d[4:0], int'(a - 6'h0D));
      else if (a >= 6'h10 && a <= 6'h12) mFall = opModel(mFall, d[4:0], int'(a - 6'h10));
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [4:0] st;
    logic [2:0] lat;
    void'($urandom(32'd4242));
    mCtrl = 3'b110; mRise = 5'h1F; mFall = 5'h1F;
    mS1 = '0; mS2 = '0; mPrev = '0; mEvtS = '0; mIrq = 0; mEvt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: reset values
    regAddr = 6'h0D; #1 chk("R5 rise reset", regRdData, 8'h1F);
    regAddr = 6'h10; #1 chk("R5 fall reset", regRdData, 8'h1F);
    regAddr = 6'h0A; #1 chk("R5 ctrl reset", regRdData, 8'h06);
    chk("R5 irq reset", irqOut, 1'b0);
    chk("R5 evt reset", evtValid, 1'b0);
    @(negedge clk);

    // R1: alias semantics on the rising mask
    step(6'h0D, 1, 8'h05, 5'h00, 0);
    step(6'h0E, 1, 8'h12, 5'h00, 0);
    chk("R1 set alias", regRdData, 8'h17);
    step(6'h0F, 1, 8'h03, 5'h00, 0);
    chk("R1 clear alias", regRdData, 8'h14);
    step(6'h0D, 1, 8'h1F, 5'h00, 0);

    // R3: unmapped writes leave every register alone
    step(6'h13, 1, 8'hFF, 5'h00, 0);
    step(6'h09, 1, 8'h00, 5'h00, 0);
    step(6'h3F, 1, 8'h00, 5'h00, 0);
    chk("R3 unmapped read", regRdData, 8'h00);
    step(6'h11, 0, 8'h00, 5'h00, 0);
    chk("R3 fall intact", regRdData, 8'h1F);
    step(6'h0B, 0, 8'h00, 5'h00, 0);
    chk("R3 ctrl intact", regRdData, 8'h06);

    // R6: latency of an enabled rising change is three edges
    step(6'h00, 0, 8'h00, 5'h02, 0); lat[0] = evtValid;
    step(6'h00, 0, 8'h00, 5'h02, 0); lat[1] = evtValid;
    step(6'h00, 0, 8'h00, 5'h02, 0); lat[2] = evtValid;
    chk("R6 latency", lat, 3'b100);
    chk("R11 snapshot", evtStatus, 5'h02);
    step(6'h00, 0, 8'h00, 5'h02, 0);
    chk("R6 single pulse", evtValid, 1'b0);
    chk("R10 sticky", irqOut, 1'b1);
    step(6'h00, 0, 8'h00, 5'h02, 1);
    chk("R10 ack clears", irqOut, 1'b0);

    // R8: masked directions stay silent; R7 enabled fall fires
    step(6'h0F, 1, 8'h1F, 5'h02, 0);
    step(6'h00, 0, 8'h00, 5'h06, 0);
    repeat (4) step(6'h00, 0, 8'h00, 5'h06, 0);
    chk("R8 masked rise", irqOut, 1'b0);
    step(6'h00, 0, 8'h00, 5'h02, 0);
    step(6'h00, 0, 8'h00, 5'h02, 0);
    step(6'h00, 0, 8'h00, 5'h02, 0);
    chk("R7 fall event", evtValid, 1'b1);
    step(6'h00, 0, 8'h00, 5'h02, 1);

    // R9: ID input high while sampling is off, then enable sampling
    step(6'h0D, 1, 8'h1F, 5'h12, 0);
    repeat (4) step(6'h00, 0, 8'h00, 5'h12, 0);
    chk("R9 gated id", irqOut, 1'b0);
    step(6'h0B, 1, 8'h01, 5'h12, 0);
    chk("R9 not yet", evtValid, 1'b0);
    step(6'h00, 0, 8'h00, 5'h12, 0);
    chk("R9 id rise", evtValid, 1'b1);
    chk("R9 id snapshot", evtStatus, 5'h12);

    // mixed random traffic
    st = 5'h12;
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] a;
      logic [4:0] flip;
      a    = 6'h08 + 6'($urandom % 12);
      flip = ($urandom % 3 == 0) ? 5'($urandom) : 5'h00;
      st   = st ^ flip;
      step(a, ($urandom % 4) == 0, 8'($urandom), st, ($urandom % 6) == 0);
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule